// File: doc/BRIEF.md
# L2 Clock-Stop Sub-Sequencer

This block stops the L2 clocks of one cluster, for its even half, its odd half or both. A parent power-management sequencer pulses `start_i` with a two-bit half select and the cluster's index. The block then walks a fixed sequence. It raises the access masks for the chosen halves, pulses a clear of the scan-region type, and issues a clock-stop command for the chosen regions. It then waits for the stop-complete flag, checks the per-region stopped status, and drops the per-half clock-sync enables. After that it waits for the matching sync-done flags to fall, raises the regional fences, and finally ORs the half select into a shared stopped-state map at the cluster's own position.

Each of the two waits has its own bound of `POLL_LIMIT` cycles. The first waits for a flag to rise and the second waits for flags to fall. The sequence ends with a one-cycle `done_o`. When something went wrong, `err_o` is raised in the same cycle and a code says which step failed. Mask, enable, fence and map outputs are levels that the sequencer only ever sets or clears in one direction. They return to their idle values only through reset.

Top module: `l2_clkstop_seq`

## Requirements
- R1: After reset, `access_mask_o`, `fence_o`, `stopped_map_o`, `done_o`, `err_o`, `busy_o` and `err_code_o` are zero, and `sync_en_o` is 2'b11.
- R2: For an accepted start with a non-empty select, the masks are applied first, in the second cycle after the start. The even half sets mask bits 2 and 10 and the odd half sets bits 3 and 11. One cycle later `scan_clr_o` pulses for one cycle. One cycle after that, `stop_cmd_o` pulses for one cycle with `stop_region_o` equal to the select.
- R3: The block samples `stop_flag_i` once per cycle, starting in the cycle after the stop command is issued, for at most `POLL_LIMIT` samples. If the flag is still low at the last sample, the sequence ends with error code 1 (stop timeout).
- R4: Once the stop completes, if any selected half has its bit clear in `region_stopped_i` (bit 0 even, bit 1 odd), the sequence ends with error code 2 (stop failed) and `sync_en_o` is unchanged.
- R5: After a good stop check, the selected bits of `sync_en_o` are cleared (bit 0 even, bit 1 odd). The block then waits until every selected bit of `sync_done_i` reads 0, for at most `POLL_LIMIT` samples. On expiry the sequence ends with error code 3 (sync-drop timeout).
- R6: `fence_o` bits (bit 0 even, bit 1 odd) for the selected halves are set only after the selected sync-done flags have been seen low. No fence is set on any error path.
- R7: On success, `stopped_map_o` is ORed with the select shifted left by 2×`cluster_idx_i`+1, and `done_o` is raised with `err_o` low and code 0.
- R8: `done_o` lasts exactly one cycle. `err_o` is high only together with `done_o`. `err_code_o` keeps its value until the next accepted start.
- R9: A start with select 2'b00 raises `done_o` in the next cycle, with no error, and changes no mask, enable, fence or map output.
- R10: `busy_o` is high while a sequence runs. A `start_i` that arrives while busy is ignored. Mask, enable, fence and map outputs hold steady during the stop poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request from the parent sequencer |
| half_sel_i | input | 2 | Half select: bit 0 even, bit 1 odd |
| cluster_idx_i | input | IDX_W | Cluster index used to place the stopped map |
| stop_flag_i | input | 1 | Clock-stop complete flag |
| region_stopped_i | input | 2 | Per-half stopped status |
| sync_done_i | input | 2 | Per-half clock-sync done flags |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| err_code_o | output | 2 | 0 none, 1 stop timeout, 2 stop failed, 3 sync-drop timeout |
| access_mask_o | output | 16 | Access mask levels |
| scan_clr_o | output | 1 | One-cycle scan-region-type clear |
| stop_cmd_o | output | 1 | One-cycle clock-stop command |
| stop_region_o | output | 2 | Regions named by the stop command |
| sync_en_o | output | 2 | Per-half clock-sync enables |
| fence_o | output | 2 | Per-half regional fences |
| stopped_map_o | output | STAT_W | Shared stopped-state map |

## Verification
Some properties are checked by assertions on every cycle:
- the order of mask, scan clear and stop command;
- the one-cycle done pulse and the coupling of error to done;
- fences rising only after the sync-done flags are low, and enables dropping only out of a clean stop check;
- the immediate finish for an empty select;
- the poll counters stepping one sample per cycle.

Other behaviour only the bench scenarios can show:
- exactly where each poll bound lies (one sample short of the limit against the limit itself);
- which error code each failure yields and which outputs it leaves untouched;
- how the map lands for different cluster indices;
- that a start arriving mid-sequence changes nothing.

// File: rtl/l2cs_pkg.sv
package l2cs_pkg;
  localparam int MASK_W  = 16;
  localparam int EVEN_LO = 2;
  localparam int EVEN_HI = 10;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_STOP_TO   = 2'd1,
    ERR_STOP_FAIL = 2'd2,
    ERR_SYNC_TO   = 2'd3
  } l2cs_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_MASK, S_SCAN, S_STOP, S_POLL_STOP, S_CHECK, S_POLL_SYNC, S_PUBLISH
  } l2cs_state_e;

  // Mask bits owned by each half; the odd half sits one bit above the even half.
  function automatic logic [MASK_W-1:0] mask_for(input logic [1:0] sel);
    logic [MASK_W-1:0] m;
    m = '0;
    m[EVEN_LO]   = sel[0];
    m[EVEN_HI]   = sel[0];
    m[EVEN_LO+1] = sel[1];
    m[EVEN_HI+1] = sel[1];
    return m;
  endfunction
endpackage

// File: rtl/l2cs_poll_timer.sv
module l2cs_poll_timer #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (clr_i)                   cnt <= '0;
    else if (run_i && cnt != LAST)    cnt <= cnt + 1'b1;
  end

  // last sample of the window
  assign expired_o = run_i && (cnt == LAST);

  // R3 / R5: one poll sample per cycle while running
  assert_poll_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !expired_o) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/l2cs_pub_map.sv
module l2cs_pub_map #(
  parameter int N_CLUSTERS = 6,
  parameter int IDX_W      = 3,
  parameter int STAT_W     = 14
) (
  input  logic [1:0]        sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [STAT_W-1:0] map_o
);
  assign map_o[0] = 1'b0;
  // cluster c owns bits 2c+1 (even half) and 2c+2 (odd half)
  for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_cl
    assign map_o[2*c+1] = (idx_i == IDX_W'(c)) && sel_i[0];
    assign map_o[2*c+2] = (idx_i == IDX_W'(c)) && sel_i[1];
  end
  for (genvar b = 2*N_CLUSTERS+1; b < STAT_W; b++) begin : g_pad
    assign map_o[b] = 1'b0;
  end
endmodule

// File: rtl/l2_clkstop_seq.sv
module l2_clkstop_seq
  import l2cs_pkg::*;
#(
  parameter int N_CLUSTERS = 6,
  parameter int POLL_LIMIT = 50000,
  parameter int IDX_W      = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
  parameter int STAT_W     = 2*N_CLUSTERS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        half_sel_i,
  input  logic [IDX_W-1:0]  cluster_idx_i,
  input  logic              stop_flag_i,
  input  logic [1:0]        region_stopped_i,
  input  logic [1:0]        sync_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic [15:0]       access_mask_o,
  output logic              scan_clr_o,
  output logic              stop_cmd_o,
  output logic [1:0]        stop_region_o,
  output logic [1:0]        sync_en_o,
  output logic [1:0]        fence_o,
  output logic [STAT_W-1:0] stopped_map_o
);
  l2cs_state_e      state;
  l2cs_err_e        err_code_q;
  logic [1:0]       sel_q;
  logic [IDX_W-1:0] idx_q;

  // named internal events
  logic in_stop_poll, in_sync_poll, stop_exp, sync_exp;
  logic region_bad, sync_dropped;
  logic [STAT_W-1:0] pub_bits;

  assign in_stop_poll = (state == S_POLL_STOP);
  assign in_sync_poll = (state == S_POLL_SYNC);
  assign region_bad   = |(sel_q & ~region_stopped_i);
  assign sync_dropped = ((sync_done_i & sel_q) == 2'b00);
  assign busy_o       = (state != S_IDLE);
  assign err_code_o   = err_code_q;

  l2cs_poll_timer #(.LIMIT(POLL_LIMIT)) u_stop_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(in_stop_poll), .clr_i(!in_stop_poll),
    .expired_o(stop_exp));

  l2cs_poll_timer #(.LIMIT(POLL_LIMIT)) u_sync_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(in_sync_poll), .clr_i(!in_sync_poll),
    .expired_o(sync_exp));

  l2cs_pub_map #(.N_CLUSTERS(N_CLUSTERS), .IDX_W(IDX_W), .STAT_W(STAT_W)) u_map (
    .sel_i(sel_q), .idx_i(idx_q), .map_o(pub_bits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      err_code_q    <= ERR_NONE;
      sel_q         <= '0;
      idx_q         <= '0;
      access_mask_o <= '0;
      scan_clr_o    <= 1'b0;
      stop_cmd_o    <= 1'b0;
      stop_region_o <= '0;
      sync_en_o     <= 2'b11;
      fence_o       <= '0;
      stopped_map_o <= '0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      scan_clr_o <= 1'b0;
      stop_cmd_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          err_code_q <= ERR_NONE;
          if (half_sel_i == 2'b00) begin
            done_o <= 1'b1;
          end else begin
            sel_q <= half_sel_i;
            idx_q <= cluster_idx_i;
            state <= S_MASK;
          end
        end
        S_MASK: begin
          access_mask_o <= access_mask_o | mask_for(sel_q);
          state         <= S_SCAN;
        end
        S_SCAN: begin
          scan_clr_o <= 1'b1;
          state      <= S_STOP;
        end
        S_STOP: begin
          stop_cmd_o    <= 1'b1;
          stop_region_o <= sel_q;
          state         <= S_POLL_STOP;
        end
        S_POLL_STOP: begin
          if (stop_flag_i) state <= S_CHECK;
          else if (stop_exp) begin
            err_code_q <= ERR_STOP_TO;
            err_o      <= 1'b1;
            done_o     <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_CHECK: begin
          if (region_bad) begin
            err_code_q <= ERR_STOP_FAIL;
            err_o      <= 1'b1;
            done_o     <= 1'b1;
            state      <= S_IDLE;
          end else begin
            sync_en_o <= sync_en_o & ~sel_q;
            state     <= S_POLL_SYNC;
          end
        end
        S_POLL_SYNC: begin
          if (sync_dropped) begin
            fence_o <= fence_o | sel_q;
            state   <= S_PUBLISH;
          end else if (sync_exp) begin
            err_code_q <= ERR_SYNC_TO;
            err_o      <= 1'b1;
            done_o     <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_PUBLISH: begin
          stopped_map_o <= stopped_map_o | pub_bits;
          done_o        <= 1'b1;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_stop_after_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd_o |-> $past(scan_clr_o));

  assert_mask_before_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd_o |-> ((access_mask_o & mask_for(stop_region_o)) == mask_for(stop_region_o)));

  assert_stop_to_from_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_code_o == ERR_STOP_TO) |-> $past(in_stop_poll && !stop_flag_i));

  assert_sync_drop_after_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en_o != $past(sync_en_o)) |-> $past(state == S_CHECK && !region_bad));

  assert_fence_after_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_o != $past(fence_o)) |-> $past((sync_done_i & sel_q) == 2'b00));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  assert_empty_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_i && half_sel_i == 2'b00) |=> (done_o && !err_o));

  assert_stable_in_poll_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop_poll && $past(in_stop_poll)) |->
      ($stable(access_mask_o) && $stable(sync_en_o) && $stable(fence_o) && $stable(stopped_map_o)));
endmodule

// File: tb/sim_l2_clkstop_seq.sv
module sim_l2_clkstop_seq;
  localparam int NCL = 6;
  localparam int LIM = 16;
  localparam int IW  = 3;
  localparam int SW  = 2*NCL + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] half_sel_i = '0;
  logic [IW-1:0] cluster_idx_i = '0;
  logic stop_flag_i = 1'b0;
  logic [1:0] region_stopped_i = 2'b11;
  logic [1:0] sync_done_i = 2'b11;
  logic busy_o, done_o, err_o, scan_clr_o, stop_cmd_o;
  logic [1:0] err_code_o, stop_region_o, sync_en_o, fence_o;
  logic [15:0] access_mask_o;
  logic [SW-1:0] stopped_map_o;

  always #10 clk = ~clk;  // 50 MHz

  l2_clkstop_seq #(.N_CLUSTERS(NCL), .POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_sel_i(half_sel_i),
    .cluster_idx_i(cluster_idx_i), .stop_flag_i(stop_flag_i),
    .region_stopped_i(region_stopped_i), .sync_done_i(sync_done_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
    .access_mask_o(access_mask_o), .scan_clr_o(scan_clr_o), .stop_cmd_o(stop_cmd_o),
    .stop_region_o(stop_region_o), .sync_en_o(sync_en_o), .fence_o(fence_o),
    .stopped_map_o(stopped_map_o));

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0]    code;
    logic [15:0]   mask;
    logic [1:0]    syncen;
    logic [1:0]    fence;
    logic [SW-1:0] map;
    string         req;
  } exp_t;
  exp_t sb[$];

  // bench model of the accumulated outputs
  logic [15:0]   m_mask;
  logic [1:0]    m_sync, m_fence, m_sd;
  logic [SW-1:0] m_map;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(err_o == (e.code != 2'd0), e.req, "err flag", err_o, e.code != 2'd0);
        chk(err_code_o == e.code, e.req, "err code", err_code_o, e.code);
        chk(access_mask_o == e.mask, e.req, "mask", access_mask_o, e.mask);
        chk(sync_en_o == e.syncen, e.req, "sync enables", sync_en_o, e.syncen);
        chk(fence_o == e.fence, e.req, "fences", fence_o, e.fence);
        chk(stopped_map_o == e.map, e.req, "stopped map", stopped_map_o, e.map);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    stop_flag_i = 1'b0;
    m_mask = '0; m_sync = 2'b11; m_fence = '0; m_sd = 2'b11; m_map = '0;
    sync_done_i = m_sd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] sel, input int idx, input int stop_lat,
                     input logic [1:0] regs, input int sync_lat, input bit poke,
                     input string req);
    exp_t e;
    int k, sc, sy;
    bit st_on, sy_on, seen;
    // expected result from the requirements
    e.req = req;
    if (sel != 2'b00) begin
      if (sel[0]) begin m_mask[2] = 1'b1; m_mask[10] = 1'b1; end
      if (sel[1]) begin m_mask[3] = 1'b1; m_mask[11] = 1'b1; end
      if (stop_lat >= LIM) e.code = 2'd1;
      else if ((sel & ~regs) != 2'b00) e.code = 2'd2;
      else begin
        m_sync = m_sync & ~sel;
        if ((m_sd & sel) != 2'b00 && sync_lat >= LIM) e.code = 2'd3;
        else begin
          e.code = 2'd0;
          m_fence = m_fence | sel;
          m_map = m_map | (SW'(sel) << (2*idx + 1));
        end
      end
    end else e.code = 2'd0;
    e.mask = m_mask; e.syncen = m_sync; e.fence = m_fence; e.map = m_map;
    sb.push_back(e);

    region_stopped_i = regs;
    stop_flag_i = 1'b0;
    half_sel_i = sel;
    cluster_idx_i = IW'(idx);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 1; sc = 0; sy = 0; st_on = 0; sy_on = 0; seen = 0;
    while (!seen && k < 400) begin
      if (done_o) begin
        seen = 1;
        if (sel == 2'b00) chk(k == 1, "R9", "done latency", k, 1);
      end else begin
        if (sel != 2'b00 && k == 1)
          chk(busy_o, "R10", "busy", busy_o, 1);
        if (sel != 2'b00 && k == 3)
          chk(scan_clr_o && !stop_cmd_o, "R2", "scan clear slot", {scan_clr_o, stop_cmd_o}, 2'b10);
        if (sel != 2'b00 && k == 4)
          chk(stop_cmd_o && stop_region_o == sel, "R2", "stop command slot",
              {stop_cmd_o, stop_region_o}, {1'b1, sel});
        if (stop_cmd_o) begin st_on = 1; sc = 0; end
        else if (st_on) sc++;
        if (st_on && sc == stop_lat) stop_flag_i = 1'b1;
        if (poke) begin
          if (st_on && sc == 1) begin start_i = 1'b1; half_sel_i = 2'b11; end
          else start_i = 1'b0;
        end
        if (!sy_on && stop_flag_i && (sync_en_o & sel) == 2'b00) begin sy_on = 1; sy = 0; end
        else if (sy_on) sy++;
        if (sy_on && sy == sync_lat && sync_lat < LIM) m_sd = m_sd & ~sel;
        sync_done_i = m_sd;
        k++;
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    if (!seen) chk(0, req, "no done", 0, 1);
    stop_flag_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    chk(0, "WD", "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(access_mask_o == 0 && fence_o == 0 && stopped_map_o == 0, "R1", "cleared outputs",
        {access_mask_o, fence_o}, 0);
    chk(sync_en_o == 2'b11, "R1", "sync enables", sync_en_o, 2'b11);
    chk(!done_o && !err_o && !busy_o && err_code_o == 0, "R1", "status",
        {done_o, err_o, busy_o, err_code_o}, 0);

    run(2'b00, 0, 0, 2'b11, 0, 0, "R9");             // empty select
    run(2'b01, 0, 3, 2'b11, 2, 0, "R7");             // even half, cluster 0
    run(2'b10, 2, LIM-1, 2'b11, LIM-1, 0, "R3");     // last-sample successes
    chk(!busy_o, "R10", "idle after done", busy_o, 0);

    do_reset();
    run(2'b11, 5, LIM, 2'b11, 0, 0, "R3");           // stop timeout
    repeat (5) @(negedge clk);
    chk(err_code_o == 2'd1, "R8", "code held", err_code_o, 1);
    run(2'b11, 5, 0, 2'b01, 0, 0, "R4");             // odd half not stopped
    run(2'b11, 5, 0, 2'b11, LIM, 0, "R5");           // sync-done stuck high
    chk(fence_o == 2'b00, "R6", "no fence after sync timeout", fence_o, 0);
    run(2'b01, 1, 0, 2'b11, 0, 1, "R10");            // start poked mid-sequence
    run(2'b11, 3, 2, 2'b11, 5, 1, "R6");             // both halves, fences after drop
    run(2'b00, 4, 0, 2'b11, 0, 0, "R9");             // empty select leaves all alone
    chk(sb.size() == 0, "R8", "all completions seen", sb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule